// File: doc/BRIEF.md
# Streaming NFA Matcher for (ab+|ba+)c

This block searches a byte stream for the fixed pattern `(ab+|ba+)c`. It does this by running a non-deterministic finite automaton in hardware. Every automaton state is one flip-flop, so several partial matches can be tracked at the same time. The start state is never stored and counts as always active. Because of that, a match may begin at any byte, and overlapping matches are all reported.

Characters arrive on a valid/ready stream input and one character is taken per cycle. The block never applies back-pressure: `in_ready` is high whenever reset is low, so a producer may hold `in_valid` high every cycle. A plain `clear` pin starts a new stream. The match result is a plain pulse, not a stream, so it has no ready. The live state vector is brought out for debug.

Top module: `regex_stream_matcher`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `match` is 0 and `active_states[5:1]` is 0. `in_ready` is 0 while `rst` is high.
- R2: `active_states[0]` (the start state) always reads 1. A byte 0x61 ('a') sets bit 1 and a byte 0x62 ('b') sets bit 2, whatever came before. Every other byte leaves bits 1 and 2 at 0.
- R3: Bit 3 is set after a 'b' exactly when bit 1 or bit 3 was set before that byte. It is 0 after any other byte.
- R4: Bit 4 is set after an 'a' exactly when bit 2 or bit 4 was set before that byte. It is 0 after any other byte.
- R5: Bit 5 (accept) is set after a 0x63 ('c') exactly when bit 3 or bit 4 was set before that byte. It is 0 after any other byte, because the accept state does not loop on itself.
- R6: `match` is high for exactly one cycle, in the cycle after each accepted byte that sets bit 5. Overlapping matches each give a pulse, so "abbcbac" gives two pulses and "abcc" gives one.
- R7: In a cycle without an accepted byte and without `clear`, `active_states` holds its value and `match` is 0 on the next cycle.
- R8: `clear` zeroes bits 1 to 5 on the next edge. If a byte is accepted in the same cycle, that byte is evaluated as the first character of a new stream.
- R9: `in_ready` is 1 in every cycle in which `rst` is 0. A byte counts as accepted when `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | 8 | Input character |
| clear | input | 1 | Start of a new stream; drops all partial matches |
| match | output | 1 | One-cycle pulse per completed match |
| active_states | output | 6 | Automaton state vector, bit n = state n |

## Verification
The assertions assume that `in_data` and `clear` are known in every cycle after reset. They also assume that `clear` is a plain level sampled at the clock edge, with no timing of its own relative to `in_valid`. The bench drives every input one time unit after the rising edge, so each value is settled well before the next sampling edge. The bench sweeps every string of length one to four over the alphabet a, b, c, d. It starts each string with `clear` together with the first byte, so each string is evaluated as a fresh stream.

// File: rtl/regex_nfa_pkg.sv
package regex_nfa_pkg;
  localparam int CHAR_W   = 8;
  localparam int N_STATES = 6;
  localparam int N_LITS   = 3;

  // state positions in the vector (behavioural: decoded by the debug port)
  localparam int ST_START = 0;
  localparam int ST_A1    = 1;
  localparam int ST_B1    = 2;
  localparam int ST_ABRUN = 3;
  localparam int ST_BARUN = 4;
  localparam int ST_ACC   = 5;

  // literal slots in the compare bank
  localparam int LIT_A = 0;
  localparam int LIT_B = 1;
  localparam int LIT_C = 2;

  typedef logic [N_STATES-1:0] state_vec_t;
  typedef logic [N_LITS-1:0]   lit_hits_t;
endpackage

// File: rtl/char_compare.sv
module char_compare #(
  parameter int W = 8,
  parameter int N = 3
) (
  input  logic [W-1:0]   ch,
  input  logic [N*W-1:0] lits,
  output logic [N-1:0]   hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = (ch == lits[i*W +: W]);
  end
endmodule

// File: rtl/nfa_step.sv
module nfa_step
  import regex_nfa_pkg::*;
(
  input  state_vec_t cur,
  input  lit_hits_t  hit,
  output state_vec_t nxt
);
  always_comb begin
    nxt           = '0;
    nxt[ST_START] = 1'b1;
    // start is implicitly armed: first-step states depend only on the byte
    nxt[ST_A1]    = hit[LIT_A];
    nxt[ST_B1]    = hit[LIT_B];
    nxt[ST_ABRUN] = hit[LIT_B] & (cur[ST_A1] | cur[ST_ABRUN]);
    nxt[ST_BARUN] = hit[LIT_A] & (cur[ST_B1] | cur[ST_BARUN]);
    nxt[ST_ACC]   = hit[LIT_C] & (cur[ST_ABRUN] | cur[ST_BARUN]);
  end
endmodule

// File: rtl/regex_stream_matcher.sv
module regex_stream_matcher
  import regex_nfa_pkg::*;
#(
  parameter logic [CHAR_W-1:0] CH_A = 8'h61,
  parameter logic [CHAR_W-1:0] CH_B = 8'h62,
  parameter logic [CHAR_W-1:0] CH_C = 8'h63
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              clear,
  output logic              match,
  output logic [N_STATES-1:0] active_states
);
  localparam logic [N_LITS*CHAR_W-1:0] LITS = {CH_C, CH_B, CH_A};

  state_vec_t st_q, st_base, st_nxt;
  lit_hits_t  hits;
  logic       take;
  logic       match_q;

  assign in_ready = ~rst;
  assign take     = in_valid & in_ready;

  char_compare #(.W(CHAR_W), .N(N_LITS)) u_cmp (
    .ch   (in_data),
    .lits (LITS),
    .hit  (hits)
  );

  // clear makes the byte of the same cycle the first of a fresh stream
  always_comb begin
    st_base = clear ? state_vec_t'(1) : st_q;
  end

  nfa_step u_step (
    .cur (st_base),
    .hit (hits),
    .nxt (st_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= state_vec_t'(1);
      match_q <= 1'b0;
    end else begin
      if (take)       st_q <= st_nxt;
      else if (clear) st_q <= state_vec_t'(1);
      match_q <= take & st_nxt[ST_ACC];
    end
  end

  assign match         = match_q;
  assign active_states = st_q | state_vec_t'(1);
endmodule

// File: rtl/regex_stream_matcher_chk.sv
module regex_stream_matcher_chk
  import regex_nfa_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CHAR_W-1:0] in_data,
  input logic              clear,
  input logic              match,
  input logic [N_STATES-1:0] active_states
);
  assert_reset_clean_R1: assert property (@(posedge clk)
    rst |=> (match == 1'b0 && active_states[5:1] == '0));

  assert_ready_up_R9: assert property (@(posedge clk) disable iff (rst)
    in_ready);

  assert_first_step_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({active_states[1], active_states[2], active_states[5]}));

  assert_abrun_src_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !clear && in_data == 8'h62 &&
     (active_states[1] || active_states[3])) |=> active_states[3]);

  assert_barun_src_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !clear && in_data == 8'h61 &&
     (active_states[2] || active_states[4])) |=> active_states[4]);

  assert_accept_src_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(active_states[5]) |-> $past(in_data == 8'h63 && !clear &&
     (active_states[3] || active_states[4])));

  assert_match_cause_R6: assert property (@(posedge clk) disable iff (rst)
    match |-> ($past(in_valid && in_ready && in_data == 8'h63) && active_states[5]));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !clear) |=> ($stable(active_states) && !match));

  assert_clear_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (clear && !in_valid) |=> (active_states[5:1] == '0 && !match));
endmodule

bind regex_stream_matcher regex_stream_matcher_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .in_data       (in_data),
  .clear         (clear),
  .match         (match),
  .active_states (active_states)
);

// File: tb/regex_stream_matcher_bench.sv
module regex_stream_matcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A = 8'h61, B = 8'h62, C = 8'h63, D = 8'h64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       clear = 1'b0;
  logic       match;
  logic [5:0] active_states;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] str [0:15];

  always #(CLK_PERIOD/2) clk = ~clk;

  regex_stream_matcher u_regex_stream_matcher (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .clear(clear), .match(match),
    .active_states(active_states)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // true when str[..e] ends with a maximal run of 'run' bytes preceded by 'lead'
  function automatic bit run_led(int e, logic [7:0] run, logic [7:0] lead);
    int q;
    if (e < 0 || str[e] != run) return 1'b0;
    q = e;
    while (q > 0 && str[q-1] == run) q--;
    return (q > 0 && str[q-1] == lead);
  endfunction

  function automatic logic [5:0] exp_vec(int i);
    logic [5:0] v;
    v    = 6'b000001;
    v[1] = (str[i] == A);
    v[2] = (str[i] == B);
    v[3] = run_led(i, B, A);
    v[4] = run_led(i, A, B);
    v[5] = (str[i] == C) && (run_led(i-1, B, A) || run_led(i-1, A, B));
    return v;
  endfunction

  // one clock edge; inputs change 1 time unit after the edge
  task automatic step(logic v, logic [7:0] d, logic clr);
    in_valid = v; in_data = d; clear = clr;
    @(posedge clk); #1;
    in_valid = 1'b0; clear = 1'b0;
  endtask

  task automatic run_str(int len, string req);
    for (int i = 0; i < len; i++) begin
      logic [5:0] e;
      step(1'b1, str[i], i == 0);
      e = exp_vec(i);
      check({req, " vec R2 R3 R4 R5"}, 32'(active_states), 32'(e));
      check({req, " match R6"}, 32'(match), 32'(e[5]));
    end
  endtask

  task automatic load(string s);
    for (int i = 0; i < s.len(); i++) str[i] = s[i];
  endtask

  initial begin
    int pulses;
    logic [5:0] held;
    // R1 reset state
    @(posedge clk); #1;
    step(1'b1, A, 1'b0);
    check("R1 ready low in reset", 32'(in_ready), 0);
    check("R1 states", 32'(active_states), 32'h1);
    check("R1 match", 32'(match), 0);
    rst = 1'b0;
    #1;
    check("R9 ready", 32'(in_ready), 1);

    // trace "adab"
    load("adab"); run_str(4, "trace");
    check("R3 adab S3", 32'(active_states[3]), 1);

    // R7 idle hold after "ab"
    load("ab"); run_str(2, "R7 prep");
    held = active_states;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, C, 1'b0);
      check("R7 hold", 32'(active_states), 32'(held));
      check("R7 no match", 32'(match), 0);
    end
    // gap then 'c' still matches
    step(1'b1, C, 1'b0);
    check("R6 match after gap", 32'(match), 1);
    step(1'b0, 8'h00, 1'b0);
    check("R6 one cycle", 32'(match), 0);

    // R8 clear without byte
    load("ab"); run_str(2, "R8 prep");
    step(1'b0, 8'h00, 1'b1);
    check("R8 clear zero", 32'(active_states), 32'h1);
    step(1'b1, C, 1'b0);
    check("R8 no match after clear", 32'(match), 0);

    // R8 clear with byte: "ab" then clear+'c' must not match
    load("ab"); run_str(2, "R8 prep2");
    step(1'b1, C, 1'b1);
    check("R8 clear with byte", 32'(match), 0);
    check("R8 clear with byte vec", 32'(active_states), 32'h1);

    // R6 overlapping: abbcbac -> 2 pulses; abcc -> 1
    load("abbcbac");
    pulses = 0;
    for (int i = 0; i < 7; i++) begin
      step(1'b1, str[i], i == 0);
      pulses += int'(match);
    end
    check("R6 overlap count", 32'(pulses), 2);
    load("abcc");
    pulses = 0;
    for (int i = 0; i < 4; i++) begin
      step(1'b1, str[i], i == 0);
      pulses += int'(match);
    end
    check("R5 accept no self loop", 32'(pulses), 1);

    // back-to-back valid every cycle, exhaustive over {a,b,c,d}^1..4
    for (int len = 1; len <= 4; len++) begin
      for (int n = 0; n < (1 << (2*len)); n++) begin
        for (int i = 0; i < len; i++) begin
          case ((n >> (2*i)) & 3)
            0: str[i] = A;
            1: str[i] = B;
            2: str[i] = C;
            default: str[i] = D;
          endcase
        end
        run_str(len, "sweep");
      end
    end
    check("R9 ready end", 32'(in_ready), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule